// File: doc/BRIEF.md
# Microstep Sine/Cosine Reference Generator

This block produces the two phase-current commands for a two-phase stepper motor driven in microstep mode. The commands are signed digital words meant for a pair of DACs. An internal electrical-angle register moves forward on a step-up pulse and backward on a step-down pulse. The register covers one electrical turn, which equals four full motor steps, so one full step spans a quarter of the register's range. The register selects an entry in a quarter-wave sine table. Quadrant logic then turns that entry into a cosine word for phase A and a sine word for phase B. The two words are 90 electrical degrees apart, so their vector sum keeps a constant length.

A 3-bit resolution select sets how far each pulse moves the angle. It chooses from one up to 128 microsteps per full step. Full-step drive is simply the coarsest setting of the same mechanism. The resolution may change between pulses. The new increment then applies from the current angle onward. Both output words are registered. A one-cycle valid strobe marks each update.

Top module: `microstep_ref_gen`

## Requirements
- R1: While reset is asserted, and after it is released with no pulse applied, the angle is 0, cosOut is +2047, sinOut is 0 and outValid is low.
- R2: A stepUp pulse without stepDown adds the increment to the 9-bit angle (512 codes per electrical turn). A stepDown pulse without stepUp subtracts it.
- R3: A resSel value k selects 2^k microsteps per full step, and the increment is 2^(7-k) codes. So k=0 gives full steps of 128 codes (90 degrees), and k=7 gives 1 code.
- R4: cosOut equals round(2047*cos(2*pi*a/512)) and sinOut equals round(2047*sin(2*pi*a/512)), within one LSB, as 12-bit two's complement, where a is the angle.
- R5: The signs follow the quadrant given by the top two angle bits. At a=128, cosOut is 0 and sinOut is +2047. At a=256, cosOut is -2047. At a=384, sinOut is -2047.
- R6: The angle wraps modulo 512 in both directions. For example, one full step down from 0 gives 384.
- R7: When stepUp and stepDown are high in the same cycle they cancel. The angle does not move, outValid stays low and both words hold their values.
- R8: Each effective pulse updates both words, and raises outValid for exactly one cycle, on the clock edge that samples the pulse. Back-to-back pulses in consecutive cycles each give their own update.
- R9: Neither word ever takes the value -2048. Its magnitude never exceeds 2047.
- R10: cosOut^2 + sinOut^2 stays within 2% of 2047^2 at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| stepUp | input | 1 | Advance pulse, one cycle per microstep |
| stepDown | input | 1 | Retreat pulse, one cycle per microstep |
| resSel | input | 3 | log2 of microsteps per full step |
| cosOut | output | 12 | Phase A command, two's complement |
| sinOut | output | 12 | Phase B command, two's complement |
| outValid | output | 1 | One-cycle strobe on each update |

## Verification
Two things can land in the same cycle: an advance and a retreat, and a resolution change and a pulse. The bench drives stepUp and stepDown high together. It then checks at the ports that no strobe appears and that both words still hold their earlier values. It also changes resSel on the same cycle as a pulse and expects the new increment to apply to that pulse. The scoreboard's angle model must then still agree with every later word.

// File: rtl/msref_pkg.sv
package msref_pkg;

  // Strobes passed from the pulse decoder to the angle datapath.
  typedef struct packed {
    logic advance;
    logic retreat;
  } stepCmd_t;

  // Decode the quadrant into sine/cosine index choices and signs.
  typedef struct packed {
    logic sinMirror;
    logic sinNeg;
    logic cosMirror;
    logic cosNeg;
  } quadMap_t;

  function automatic quadMap_t quadDecode(input logic [1:0] q);
    quadMap_t m;
    unique case (q)
      2'd0: m = '{sinMirror: 1'b0, sinNeg: 1'b0, cosMirror: 1'b1, cosNeg: 1'b0};
      2'd1: m = '{sinMirror: 1'b1, sinNeg: 1'b0, cosMirror: 1'b0, cosNeg: 1'b1};
      2'd2: m = '{sinMirror: 1'b0, sinNeg: 1'b1, cosMirror: 1'b1, cosNeg: 1'b1};
      default: m = '{sinMirror: 1'b1, sinNeg: 1'b1, cosMirror: 1'b0, cosNeg: 1'b0};
    endcase
    return m;
  endfunction

endpackage

// File: rtl/msref_quarter_rom.sv
module msref_quarter_rom #(
  parameter int IDX_W = 7,
  parameter int MAG_W = 11
) (
  input  logic [IDX_W:0]   idx,
  output logic [MAG_W-1:0] mag
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int FULL = (1 << MAG_W) - 1;
  localparam real TWO_PI = 6.283185307179586;

  function automatic int sampleAt(input int j);
    real r;
    r = real'(FULL) * $sin(TWO_PI * real'(j) / real'(4 * DEPTH));
    return $rtoi(r + 0.5);
  endfunction

  logic [MAG_W-1:0] tbl [DEPTH];

  for (genvar j = 0; j < DEPTH; j++) begin : g_entry
    localparam int VAL = sampleAt(j);
    assign tbl[j] = MAG_W'(VAL);
  end

  // Index DEPTH is the crest, which the quarter table does not hold.
  assign mag = idx[IDX_W] ? MAG_W'(FULL) : tbl[idx[IDX_W-1:0]];

endmodule

// File: rtl/msref_control.sv
module msref_control
  import msref_pkg::*;
#(
  parameter int ANGLE_W = 9,
  parameter int RES_W = 3
) (
  input  logic               stepUp,
  input  logic               stepDown,
  input  logic [RES_W-1:0]   resSel,
  output stepCmd_t           cmd,
  output logic [ANGLE_W-1:0] stepSize
);
  localparam int IDX_W = ANGLE_W - 2;

  logic [RES_W-1:0] resClamped;

  always_comb begin
    cmd.advance = stepUp & ~stepDown;
    cmd.retreat = stepDown & ~stepUp;
    if (int'(resSel) > IDX_W) resClamped = RES_W'(IDX_W);
    else resClamped = resSel;
    stepSize = ANGLE_W'(1) << (IDX_W - int'(resClamped));
  end

endmodule

// File: rtl/msref_datapath.sv
module msref_datapath
  import msref_pkg::*;
#(
  parameter int ANGLE_W = 9,
  parameter int OUT_W = 12
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  stepCmd_t                cmd,
  input  logic [ANGLE_W-1:0]      stepSize,
  output logic signed [OUT_W-1:0] cosOut,
  output logic signed [OUT_W-1:0] sinOut,
  output logic                    outValid
);
  localparam int IDX_W = ANGLE_W - 2;
  localparam int MAG_W = OUT_W - 1;
  localparam int DEPTH = 1 << IDX_W;
  localparam int FULL = (1 << MAG_W) - 1;

  logic [ANGLE_W-1:0] angleQ, angleNext;
  logic [IDX_W:0]     fineIdx, mirrorIdx, sinIdx, cosIdx;
  logic [MAG_W-1:0]   sinMag, cosMag;
  logic signed [OUT_W-1:0] sinVal, cosVal;
  quadMap_t           qm;
  logic               moveNow;

  assign moveNow = cmd.advance | cmd.retreat;

  always_comb begin
    angleNext = angleQ;
    if (cmd.advance) angleNext = angleQ + stepSize;
    else if (cmd.retreat) angleNext = angleQ - stepSize;
  end

  always_comb begin
    qm = quadDecode(angleNext[ANGLE_W-1 -: 2]);
    fineIdx = {1'b0, angleNext[IDX_W-1:0]};
    mirrorIdx = (IDX_W+1)'(DEPTH) - fineIdx;
    sinIdx = qm.sinMirror ? mirrorIdx : fineIdx;
    cosIdx = qm.cosMirror ? mirrorIdx : fineIdx;
  end

  msref_quarter_rom #(.IDX_W(IDX_W), .MAG_W(MAG_W)) uSinRom (
    .idx(sinIdx), .mag(sinMag)
  );

  msref_quarter_rom #(.IDX_W(IDX_W), .MAG_W(MAG_W)) uCosRom (
    .idx(cosIdx), .mag(cosMag)
  );

  always_comb begin
    sinVal = qm.sinNeg ? -$signed({1'b0, sinMag}) : $signed({1'b0, sinMag});
    cosVal = qm.cosNeg ? -$signed({1'b0, cosMag}) : $signed({1'b0, cosMag});
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      angleQ   <= '0;
      cosOut   <= OUT_W'(FULL);
      sinOut   <= '0;
      outValid <= 1'b0;
    end else begin
      outValid <= moveNow;
      if (moveNow) begin
        angleQ <= angleNext;
        cosOut <= cosVal;
        sinOut <= sinVal;
      end
    end
  end

endmodule

// File: rtl/microstep_ref_gen.sv
module microstep_ref_gen
  import msref_pkg::*;
#(
  parameter int ANGLE_W = 9,
  parameter int OUT_W = 12,
  parameter int RES_W = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    stepUp,
  input  logic                    stepDown,
  input  logic [RES_W-1:0]        resSel,
  output logic signed [OUT_W-1:0] cosOut,
  output logic signed [OUT_W-1:0] sinOut,
  output logic                    outValid
);
  stepCmd_t           cmd;
  logic [ANGLE_W-1:0] stepSize;

  msref_control #(.ANGLE_W(ANGLE_W), .RES_W(RES_W)) uCtrl (
    .stepUp(stepUp), .stepDown(stepDown), .resSel(resSel),
    .cmd(cmd), .stepSize(stepSize)
  );

  msref_datapath #(.ANGLE_W(ANGLE_W), .OUT_W(OUT_W)) uData (
    .clk(clk), .rstN(rstN), .cmd(cmd), .stepSize(stepSize),
    .cosOut(cosOut), .sinOut(sinOut), .outValid(outValid)
  );

endmodule

// File: rtl/msref_checker.sv
module msref_checker #(
  parameter int OUT_W = 12
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    stepUp,
  input logic                    stepDown,
  input logic signed [OUT_W-1:0] cosOut,
  input logic signed [OUT_W-1:0] sinOut,
  input logic                    outValid
);
  localparam longint FULL = (longint'(1) << (OUT_W - 1)) - 1;
  localparam longint FULL_SQ = FULL * FULL;
  localparam logic signed [OUT_W-1:0] MOST_NEG = {1'b1, {(OUT_W-1){1'b0}}};

  longint sumSq;
  always_comb sumSq = longint'(cosOut) * longint'(cosOut) + longint'(sinOut) * longint'(sinOut);

  // R8: strobe follows exactly one effective pulse per cycle
  assert_valid_tracks_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    outValid == $past(stepUp ^ stepDown));

  // R7: no effective pulse means both words hold
  assert_hold_without_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(stepUp ^ stepDown) |=> ($stable(cosOut) && $stable(sinOut)));

  // R9: the most negative code never appears
  assert_no_most_negative_R9: assert property (@(posedge clk) disable iff (!rstN)
    (cosOut != MOST_NEG) && (sinOut != MOST_NEG));

  // R10: phasor length stays near full scale
  assert_constant_amplitude_R10: assert property (@(posedge clk) disable iff (!rstN)
    (sumSq * 50 >= FULL_SQ * 49) && (sumSq * 50 <= FULL_SQ * 51));

endmodule

bind microstep_ref_gen msref_checker #(.OUT_W(OUT_W)) uChk (
  .clk(clk), .rstN(rstN), .stepUp(stepUp), .stepDown(stepDown),
  .cosOut(cosOut), .sinOut(sinOut), .outValid(outValid)
);

// File: tb/microstep_ref_gen_test.sv
module microstep_ref_gen_test;
  localparam real TWO_PI = 6.283185307179586;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic stepUp = 1'b0, stepDown = 1'b0;
  logic [2:0] resSel = 3'd0;
  logic signed [11:0] cosOut, sinOut;
  logic outValid;

  typedef struct {
    int    cosE;
    int    sinE;
    string tag;
  } item_t;

  item_t expQ[$];
  int checks = 0, fails = 0, cycles = 0, ang = 0;
  string curTag = "R2";

  always #5 clk = ~clk;

  microstep_ref_gen uut (
    .clk(clk), .rstN(rstN), .stepUp(stepUp), .stepDown(stepDown),
    .resSel(resSel), .cosOut(cosOut), .sinOut(sinOut), .outValid(outValid)
  );

  function automatic int roundR(input real x);
    if (x >= 0.0) return $rtoi(x + 0.5);
    return -$rtoi(-x + 0.5);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  // Driver: one pulse per call, expected item pushed for effective pulses.
  task automatic pulse(input bit u, input bit d, input int k);
    item_t it;
    @(negedge clk);
    stepUp = u;
    stepDown = d;
    resSel = 3'(k);
    if (u ^ d) begin
      if (u) ang = (ang + (1 << (7 - k))) & 511;
      else   ang = (ang - (1 << (7 - k))) & 511;
      it.cosE = roundR(2047.0 * $cos(TWO_PI * ang / 512.0));
      it.sinE = roundR(2047.0 * $sin(TWO_PI * ang / 512.0));
      it.tag = curTag;
      expQ.push_back(it);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      stepUp = 1'b0;
      stepDown = 1'b0;
    end
  endtask

  // Monitor: pops and compares on every strobe.
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R7/R8 unexpected strobe", 1, 0);
      end else begin
        item_t e;
        int c, s;
        e = expQ.pop_front();
        c = int'(cosOut);
        s = int'(sinOut);
        check((c - e.cosE <= 1) && (e.cosE - c <= 1), {e.tag, " R4 cos"}, c, e.cosE);
        check((s - e.sinE <= 1) && (e.sinE - s <= 1), {e.tag, " R4 sin"}, s, e.sinE);
        check((c != -2048) && (s != -2048), "R9 magnitude", (c < s) ? c : s, -2047);
        check((c*c + s*s) * 50 >= 4190209 * 49 && (c*c + s*s) * 50 <= 4190209 * 51,
              "R10 amplitude", c*c + s*s, 4190209);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      finishRun();
    end
  end

  initial begin
    int pc, ps;
    repeat (2) @(negedge clk);
    check(cosOut == 12'sd2047 && sinOut == 0 && !outValid, "R1 in reset", int'(cosOut), 2047);
    rstN = 1'b1;
    @(negedge clk);
    check(cosOut == 12'sd2047 && sinOut == 0 && !outValid, "R1 after reset", int'(sinOut), 0);

    // R2/R8: finest resolution, back-to-back pulses
    curTag = "R2 R8 fine";
    for (int i = 0; i < 5; i++) pulse(1, 0, 7);
    idle(2);

    // R3/R5/R6: full steps around the circle
    curTag = "R3 R5 R6 fullstep";
    ang = ang;
    for (int i = 0; i < 5; i++) pulse(0, 1, 7);
    for (int i = 0; i < 4; i++) pulse(1, 0, 0);
    idle(1);
    @(negedge clk);
    check(cosOut == 12'sd2047 && sinOut == 0, "R6 full turn back to 0", int'(cosOut), 2047);
    pulse(1, 0, 0);
    idle(1);
    check(cosOut == 0 && sinOut == 12'sd2047, "R5 angle 128", int'(sinOut), 2047);
    pulse(1, 0, 0);
    idle(1);
    check(cosOut == -12'sd2047 && sinOut == 0, "R5 angle 256", int'(cosOut), -2047);
    pulse(0, 1, 0);
    pulse(0, 1, 0);
    pulse(0, 1, 0);
    idle(1);
    check(cosOut == 0 && sinOut == -12'sd2047, "R5 R6 wrap down to 384", int'(sinOut), -2047);

    // R3: quarter steps of 22.5 degrees, resolution changed with the pulse
    curTag = "R3 quarter";
    for (int i = 0; i < 6; i++) pulse(1, 0, 2);
    pulse(1, 0, 5);
    pulse(0, 1, 2);
    idle(1);

    // R7: simultaneous pulses cancel
    curTag = "R7";
    @(negedge clk);
    pc = int'(cosOut);
    ps = int'(sinOut);
    stepUp = 1'b1;
    stepDown = 1'b1;
    @(negedge clk);
    stepUp = 1'b0;
    stepDown = 1'b0;
    check(!outValid, "R7 no strobe", int'(outValid), 0);
    check(int'(cosOut) == pc && int'(sinOut) == ps, "R7 hold", int'(cosOut), pc);
    pulse(1, 0, 4);

    // R4/R9/R10: full sweep at 8 microsteps per step, both directions
    curTag = "R4 sweep";
    for (int i = 0; i < 32; i++) pulse(1, 0, 3);
    for (int i = 0; i < 32; i++) pulse(0, 1, 3);
    idle(3);

    check(expQ.size() == 0, "R8 all updates seen", expQ.size(), 0);
    finishRun();
  end

endmodule